// File: doc/BRIEF.md
# CPU Interrupt Request Controller

This block collects hardware events for an 8-bit processor and turns them into two active-low outputs. The first is a maskable level request, `irq_n`. The second is a non-maskable strobe, `nmi_n`. Software programs an 8-bit enable register and reads an 8-bit status register. Both sit at the same I/O port: a write reaches the enable register and a read returns status. A second port takes write-only acknowledge data.

The status register holds two kinds of bit. The first kind is latched and stays set until software acknowledges it: lid-open edge, address-line wake during coma, battery low, and keyboard column activity while asleep. The second kind is live and cannot be acknowledged. The serial-port bit is the OR of four masked sub-events. The time bit is the OR of three masked clock events.

A registered state machine drives the request. `IRQ_IDLE` moves to `IRQ_RAISED` when the request term is true. `IRQ_RAISED` returns to `IRQ_IDLE` when the term is false. A second state machine drives the non-maskable strobe:
- `NMI_IDLE` moves to `NMI_FIRE` when any critical input rises.
- `NMI_FIRE` moves to `NMI_HOLD` when a new rise arrives, and otherwise returns to `NMI_IDLE`.
- `NMI_HOLD` always moves to `NMI_FIRE`.

Top module: `cpu_irq_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `irq_n` and `nmi_n` are 1, the enable register is 0, every latched status bit is 0 and `snooze_on_kbd_read` is 0.
- R2: A write with `io_addr == EN_PORT` loads `io_wdata` into the enable register at the next clock edge. Enable bit 7 appears on `snooze_on_kbd_read`.
- R3: When `io_rd` is high and `io_addr == EN_PORT`, `io_rdata` returns status combinationally. Status bits are: 7 live lid level, 6 wake, 5 lid edge, 4 serial, 3 battery, 2 keyboard, 1 always 0, 0 time. At any other address, or with `io_rd` low, `io_rdata` is 0.
- R4: The request term is enable bit 0 AND the OR of six pairs: (status6 & enable6), (status5 & enable5), (status4 & enable4), (status3 & enable3), (status2 & enable2) and (status0 & enable1). `irq_n` is 0 exactly in the cycle after a clock edge at which the term was true.
- R5: While enable bit 0 is 0, `irq_n` stays 1 whatever the status.
- R6: Status bit 5 sets only on a rising edge of `lid_open`. Status bit 7 follows `lid_open` and never contributes to the request.
- R7: Status bit 6 sets at an edge where `coma` and `addr_hi` are both high. Bit 3 sets at an edge where `batt_low` is high. Bit 2 sets at an edge where `snooze` or `coma` is high and any `kbd_col_n` bit is low.
- R8: An acknowledge write (`io_addr == ACK_PORT`) with a 1 in bit 6, 5, 3 or 2 clears that latched status bit. Ones in bits 7, 4, 1 and 0 do nothing, and no acknowledge write changes the enable register.
- R9: If a set condition and an acknowledge of the same bit occur at the same edge, the bit stays set.
- R10: Status bit 4 equals the OR of `uart_evt & uart_mask` at all times, and an acknowledge does not clear it.
- R11: Status bit 0 equals the OR of `rtc_evt & rtc_mask` at all times.
- R12: A rising edge on any `crit_evt` bit, seen from `NMI_IDLE`, drives `nmi_n` low for exactly one cycle after that edge. A held level does not retrigger, and no acknowledge is needed.
- R13: A new rising edge that arrives while `nmi_n` is low produces a second one-cycle low pulse, separated from the first by one high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (status) |
| lid_open | input | 1 | Lid switch level, 1 = open |
| coma | input | 1 | Deep-sleep state indication |
| snooze | input | 1 | Light-sleep state indication |
| addr_hi | input | 1 | Top address line level used for wake |
| batt_low | input | 1 | Battery low indication |
| kbd_col_n | input | NCOL | Keyboard column lines, active low |
| uart_evt | input | UART_SRC | Serial-port sub-events |
| uart_mask | input | UART_SRC | Serial-port sub-event masks |
| rtc_evt | input | RTC_SRC | Clock tick, second and minute events |
| rtc_mask | input | RTC_SRC | Clock event masks |
| crit_evt | input | NCRIT | Critical events (power fail, card change) |
| irq_n | output | 1 | Maskable request, active low level |
| nmi_n | output | 1 | Non-maskable strobe, active low |
| snooze_on_kbd_read | output | 1 | Enable bit 7 |

## Verification
The bench builds the controller with four keyboard columns and two critical inputs. It keeps the default four serial and three clock sub-sources, so every event and mask pair can be swept in full: 256 and 64 combinations. Each of the six request sources is driven on its own against all 256 enable values, and the expected `irq_n` is computed from the pair table. The single-bit acknowledge sweep, the same-edge set-versus-clear race and back-to-back critical edges cover the latching and strobe corners.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
    localparam int REG_W = 8;

    // status bit positions (read side of the shared port)
    localparam int ST_LID_LVL  = 7;
    localparam int ST_WAKE     = 6;
    localparam int ST_LID_EDGE = 5;
    localparam int ST_UART     = 4;
    localparam int ST_BATT     = 3;
    localparam int ST_KBD      = 2;
    localparam int ST_TIME     = 0;

    // enable bit positions (write side of the shared port)
    localparam int EN_SNOOZE = 7;
    localparam int EN_WAKE   = 6;
    localparam int EN_LID    = 5;
    localparam int EN_UART   = 4;
    localparam int EN_BATT   = 3;
    localparam int EN_KBD    = 2;
    localparam int EN_RTC    = 1;
    localparam int EN_GLOBAL = 0;

    localparam logic [REG_W-1:0] LATCH_MASK =
        (8'd1 << ST_WAKE) | (8'd1 << ST_LID_EDGE) | (8'd1 << ST_BATT) | (8'd1 << ST_KBD);

    localparam int N_PAIRS = 6;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_FIRE = 2'd1,
        NMI_HOLD = 2'd2
    } nmi_state_e;
endpackage

// File: rtl/cpu_irq_bus.sv
module cpu_irq_bus
    import cpu_irq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] EN_PORT  = 'h40,
    parameter logic [ADDR_W-1:0] ACK_PORT = 'h41
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [REG_W-1:0]  io_wdata,
    input  logic [REG_W-1:0]  status,
    output logic [REG_W-1:0]  io_rdata,
    output logic [REG_W-1:0]  en_q,
    output logic              ack_stb,
    output logic [REG_W-1:0]  ack_clr
);
    logic en_hit;
    logic rd_hit;

    always_comb begin
        en_hit  = io_wr && (io_addr == EN_PORT);
        ack_stb = io_wr && (io_addr == ACK_PORT);
        rd_hit  = io_rd && (io_addr == EN_PORT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_hit) begin
            en_q <= io_wdata;
        end
    end

    // only the latched positions can be cleared
    always_comb begin
        ack_clr  = ack_stb ? (io_wdata & LATCH_MASK) : '0;
        io_rdata = rd_hit ? status : '0;
    end
endmodule

// File: rtl/cpu_irq_src_or.sv
module cpu_irq_src_or #(
    parameter int N = 4
) (
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    output logic         hit
);
    always_comb hit = |(evt & mask);
endmodule

// File: rtl/cpu_irq_status.sv
module cpu_irq_status
    import cpu_irq_pkg::*;
#(
    parameter int NCOL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lid_open,
    input  logic             coma,
    input  logic             snooze,
    input  logic             addr_hi,
    input  logic             batt_low,
    input  logic [NCOL-1:0]  kbd_col_n,
    input  logic             uart_live,
    input  logic             time_live,
    input  logic [REG_W-1:0] ack_clr,
    output logic [REG_W-1:0] status
);
    logic             lid_q;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lid_q <= 1'b0;
        end else begin
            lid_q <= lid_open;
        end
    end

    always_comb begin
        set_v              = '0;
        set_v[ST_WAKE]     = coma & addr_hi;
        set_v[ST_LID_EDGE] = lid_open & ~lid_q;
        set_v[ST_BATT]     = batt_low;
        set_v[ST_KBD]      = (snooze | coma) & ~(&kbd_col_n);
    end

    // a set at the same edge as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else begin
            latch_q <= (set_v | (latch_q & ~ack_clr)) & LATCH_MASK;
        end
    end

    always_comb begin
        status              = latch_q;
        status[ST_LID_LVL]  = lid_open;
        status[ST_UART]     = uart_live;
        status[ST_TIME]     = time_live;
    end
endmodule

// File: rtl/cpu_irq_req_fsm.sv
module cpu_irq_req_fsm
    import cpu_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] en_q,
    output logic             irq_n
);
    irq_state_e           state_q;
    irq_state_e           state_d;
    logic [N_PAIRS-1:0]   pair;
    logic                 req;

    always_comb begin
        pair[0] = status[ST_WAKE]     & en_q[EN_WAKE];
        pair[1] = status[ST_LID_EDGE] & en_q[EN_LID];
        pair[2] = status[ST_UART]     & en_q[EN_UART];
        pair[3] = status[ST_BATT]     & en_q[EN_BATT];
        pair[4] = status[ST_KBD]      & en_q[EN_KBD];
        pair[5] = status[ST_TIME]     & en_q[EN_RTC];
        req     = en_q[EN_GLOBAL] & (|pair);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (req)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!req) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb irq_n = (state_q != IRQ_RAISED);
endmodule

// File: rtl/cpu_irq_nmi_fsm.sv
module cpu_irq_nmi_fsm
    import cpu_irq_pkg::*;
#(
    parameter int NCRIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCRIT-1:0] crit_evt,
    output logic             nmi_n
);
    logic [NCRIT-1:0] crit_q;
    logic             rise;
    nmi_state_e       state_q;
    nmi_state_e       state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            crit_q <= '0;
        end else begin
            crit_q <= crit_evt;
        end
    end

    always_comb rise = |(crit_evt & ~crit_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: if (rise) state_d = NMI_FIRE;
            NMI_FIRE: state_d = rise ? NMI_HOLD : NMI_IDLE;
            NMI_HOLD: state_d = NMI_FIRE;
            default:  state_d = NMI_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NMI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb nmi_n = (state_q != NMI_FIRE);
endmodule

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl
    import cpu_irq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] EN_PORT  = 'h40,
    parameter logic [ADDR_W-1:0] ACK_PORT = 'h41,
    parameter int                NCOL     = 8,
    parameter int                NCRIT    = 3,
    parameter int                UART_SRC = 4,
    parameter int                RTC_SRC  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic                lid_open,
    input  logic                coma,
    input  logic                snooze,
    input  logic                addr_hi,
    input  logic                batt_low,
    input  logic [NCOL-1:0]     kbd_col_n,
    input  logic [UART_SRC-1:0] uart_evt,
    input  logic [UART_SRC-1:0] uart_mask,
    input  logic [RTC_SRC-1:0]  rtc_evt,
    input  logic [RTC_SRC-1:0]  rtc_mask,
    input  logic [NCRIT-1:0]    crit_evt,
    output logic                irq_n,
    output logic                nmi_n,
    output logic                snooze_on_kbd_read
);
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] ack_clr;
    logic             ack_stb;
    logic             uart_live;
    logic             time_live;

    cpu_irq_bus #(
        .ADDR_W  (ADDR_W),
        .EN_PORT (EN_PORT),
        .ACK_PORT(ACK_PORT)
    ) u_bus (
        .clk     (clk),
        .rst     (rst),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_wdata(io_wdata),
        .status  (status),
        .io_rdata(io_rdata),
        .en_q    (en_q),
        .ack_stb (ack_stb),
        .ack_clr (ack_clr)
    );

    cpu_irq_src_or #(.N(UART_SRC)) u_uart_or (
        .evt (uart_evt),
        .mask(uart_mask),
        .hit (uart_live)
    );

    cpu_irq_src_or #(.N(RTC_SRC)) u_rtc_or (
        .evt (rtc_evt),
        .mask(rtc_mask),
        .hit (time_live)
    );

    cpu_irq_status #(.NCOL(NCOL)) u_status (
        .clk      (clk),
        .rst      (rst),
        .lid_open (lid_open),
        .coma     (coma),
        .snooze   (snooze),
        .addr_hi  (addr_hi),
        .batt_low (batt_low),
        .kbd_col_n(kbd_col_n),
        .uart_live(uart_live),
        .time_live(time_live),
        .ack_clr  (ack_clr),
        .status   (status)
    );

    cpu_irq_req_fsm u_req (
        .clk   (clk),
        .rst   (rst),
        .status(status),
        .en_q  (en_q),
        .irq_n (irq_n)
    );

    cpu_irq_nmi_fsm #(.NCRIT(NCRIT)) u_nmi (
        .clk     (clk),
        .rst     (rst),
        .crit_evt(crit_evt),
        .nmi_n   (nmi_n)
    );

    always_comb snooze_on_kbd_read = en_q[EN_SNOOZE];
endmodule

// File: rtl/cpu_irq_ctrl_chk.sv
module cpu_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq_n,
    input logic       nmi_n,
    input logic [7:0] en_q,
    input logic [7:0] status,
    input logic       ack_stb,
    input logic       lid_open
);
    a_r5_global_gate: assert property (@(posedge clk) disable iff (rst)
        !$past(en_q[0]) |-> irq_n);

    a_r4_lid_raises: assert property (@(posedge clk) disable iff (rst)
        $past(en_q[0] && en_q[5] && status[5]) |-> !irq_n);

    a_r4_quiet_release: assert property (@(posedge clk) disable iff (rst)
        $past(status[6:0] == 7'd0) |-> irq_n);

    a_r6_lid_edge_only: assert property (@(posedge clk) disable iff (rst)
        $rose(status[5]) |-> $past(lid_open));

    a_r8_ack_keeps_enable: assert property (@(posedge clk) disable iff (rst)
        ack_stb |=> $stable(en_q));

    a_r12_nmi_single: assert property (@(posedge clk) disable iff (rst)
        !nmi_n |=> nmi_n);
endmodule

bind cpu_irq_ctrl cpu_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_n   (irq_n),
    .nmi_n   (nmi_n),
    .en_q    (en_q),
    .status  (status),
    .ack_stb (ack_stb),
    .lid_open(lid_open)
);

// File: tb/cpu_irq_ctrl_tb.sv
module cpu_irq_ctrl_tb;
    localparam int         NCOL  = 4;
    localparam int         NCRIT = 2;
    localparam logic [7:0] ENP   = 8'h40;
    localparam logic [7:0] ACKP  = 8'h41;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       io_addr = '0;
    logic             io_wr = 1'b0;
    logic             io_rd = 1'b0;
    logic [7:0]       io_wdata = '0;
    logic [7:0]       io_rdata;
    logic             lid_open = 1'b0;
    logic             coma = 1'b0;
    logic             snooze = 1'b0;
    logic             addr_hi = 1'b0;
    logic             batt_low = 1'b0;
    logic [NCOL-1:0]  kbd_col_n = '1;
    logic [3:0]       uart_evt = '0;
    logic [3:0]       uart_mask = '0;
    logic [2:0]       rtc_evt = '0;
    logic [2:0]       rtc_mask = '0;
    logic [NCRIT-1:0] crit_evt = '0;
    logic             irq_n;
    logic             nmi_n;
    logic             snooze_on_kbd_read;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    cpu_irq_ctrl #(
        .ADDR_W(8), .EN_PORT(ENP), .ACK_PORT(ACKP),
        .NCOL(NCOL), .NCRIT(NCRIT), .UART_SRC(4), .RTC_SRC(3)
    ) u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .lid_open(lid_open),
        .coma(coma), .snooze(snooze), .addr_hi(addr_hi), .batt_low(batt_low),
        .kbd_col_n(kbd_col_n), .uart_evt(uart_evt), .uart_mask(uart_mask),
        .rtc_evt(rtc_evt), .rtc_mask(rtc_mask), .crit_evt(crit_evt),
        .irq_n(irq_n), .nmi_n(nmi_n), .snooze_on_kbd_read(snooze_on_kbd_read)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        io_addr = a;
        io_rd   = 1'b1;
        #1;
        v       = io_rdata;
        io_rd   = 1'b0;
    endtask

    // source index: 0 wake, 1 lid, 2 uart, 3 batt, 4 kbd, 5 time
    function automatic int en_bit(input int s);
        int t[6] = '{6, 5, 4, 3, 2, 1};
        return t[s];
    endfunction

    function automatic logic [7:0] st_exp(input int s);
        logic [7:0] t[6] = '{8'h40, 8'hA0, 8'h10, 8'h08, 8'h04, 8'h01};
        return t[s];
    endfunction

    task automatic raise_src(input int s);
        case (s)
            0: begin coma = 1; addr_hi = 1; cyc(); coma = 0; addr_hi = 0; end
            1: begin lid_open = 1; cyc(); end
            2: begin uart_evt = 4'b0001; uart_mask = 4'b0001; end
            3: begin batt_low = 1; cyc(); batt_low = 0; end
            4: begin snooze = 1; kbd_col_n = 4'b1110; cyc(); snooze = 0; kbd_col_n = '1; end
            default: begin rtc_evt = 3'b001; rtc_mask = 3'b001; end
        endcase
    endtask

    task automatic quiet();
        lid_open = 0; coma = 0; addr_hi = 0; batt_low = 0; snooze = 0;
        kbd_col_n = '1; uart_evt = '0; uart_mask = '0; rtc_evt = '0; rtc_mask = '0;
        wr(ENP, 8'h00);
        wr(ACKP, 8'hFF);
        cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp;

        // R1: reset state
        cyc(); cyc(); cyc();
        chk("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
        chk("R1 nmi_n in reset", {7'd0, nmi_n}, 8'h01);
        rst = 1'b0;
        cyc();
        rd(ENP, v);
        chk("R1 status after reset", v, 8'h00);
        chk("R1 snooze bit after reset", {7'd0, snooze_on_kbd_read}, 8'h00);
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        // R2 / R3: enable write, bit7 output, read decode
        wr(ENP, 8'h80);
        chk("R2 snooze bit set", {7'd0, snooze_on_kbd_read}, 8'h01);
        lid_open = 1; #1;
        rd(8'h55, v);
        chk("R3 other address reads zero", v, 8'h00);
        io_addr = ENP; #1;
        chk("R3 no read strobe reads zero", io_rdata, 8'h00);
        quiet();

        // R4 / R5 / R7 / R10 / R11: each source against all enable values
        for (int s = 0; s < 6; s++) begin
            raise_src(s);
            rd(ENP, v);
            chk($sformatf("R3 R7 status layout src%0d", s), v, st_exp(s));
            for (int e = 0; e < 256; e++) begin
                logic [7:0] ev;
                ev = e[7:0];
                wr(ENP, ev);
                cyc();
                exp = {7'd0, !(ev[0] && ev[en_bit(s)])};
                chk($sformatf("R4 R5 irq_n src%0d en%02h", s, ev), {7'd0, irq_n}, exp);
            end
            quiet();
            rd(ENP, v);
            chk($sformatf("R8 cleared after src%0d", s), v, 8'h00);
        end

        // R6: lid level never requests; edge bit clears and stays clear
        wr(ENP, 8'hA1);
        lid_open = 1;
        cyc(); cyc();
        chk("R6 lid edge raises irq", {7'd0, irq_n}, 8'h00);
        wr(ACKP, 8'h20);
        cyc();
        chk("R6 irq released after ack", {7'd0, irq_n}, 8'h01);
        repeat (5) cyc();
        chk("R6 held level no request", {7'd0, irq_n}, 8'h01);
        rd(ENP, v);
        chk("R6 level bit only", v, 8'h80);
        quiet();

        // R8: single-bit acknowledge sweep
        wr(ENP, 8'h80);
        coma = 1; addr_hi = 1; lid_open = 1; batt_low = 1; kbd_col_n = 4'b0111;
        cyc();
        coma = 0; addr_hi = 0; lid_open = 0; batt_low = 0; kbd_col_n = '1;
        cyc();
        exp = 8'h6C;
        rd(ENP, v);
        chk("R7 all latched set", v, exp);
        for (int b = 0; b < 8; b++) begin
            logic [7:0] m;
            m = 8'd1 << b;
            wr(ACKP, m);
            exp = exp & ~(m & 8'h6C);
            rd(ENP, v);
            chk($sformatf("R8 ack bit %0d", b), v, exp);
        end
        chk("R8 enable untouched by ack", {7'd0, snooze_on_kbd_read}, 8'h01);
        quiet();

        // R9: set and clear at the same edge
        lid_open = 1;
        wr(ACKP, 8'h20);
        rd(ENP, v);
        chk("R9 lid edge beats ack", v, 8'hA0);
        batt_low = 1;
        cyc();
        wr(ACKP, 8'h08);
        rd(ENP, v);
        chk("R9 batt level beats ack", v & 8'h08, 8'h08);
        quiet();

        // R10: serial sweep, R11: clock sweep
        for (int e = 0; e < 16; e++) begin
            for (int m = 0; m < 16; m++) begin
                uart_evt = e[3:0]; uart_mask = m[3:0];
                rd(ENP, v);
                exp = ((e & m) != 0) ? 8'h10 : 8'h00;
                chk($sformatf("R10 uart e%0d m%0d", e, m), v, exp);
            end
        end
        uart_evt = 4'b1000; uart_mask = 4'b1000;
        wr(ACKP, 8'hFF);
        rd(ENP, v);
        chk("R10 live bit not acknowledged", v, 8'h10);
        uart_evt = '0; uart_mask = '0;
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                rtc_evt = e[2:0]; rtc_mask = m[2:0];
                rd(ENP, v);
                exp = ((e & m) != 0) ? 8'h01 : 8'h00;
                chk($sformatf("R11 rtc e%0d m%0d", e, m), v, exp);
            end
        end
        quiet();

        // R12: one-cycle strobe per input, held level does not retrigger
        for (int i = 0; i < NCRIT; i++) begin
            crit_evt = '0;
            crit_evt[i] = 1'b1;
            cyc();
            chk($sformatf("R12 strobe low crit%0d", i), {7'd0, nmi_n}, 8'h00);
            cyc();
            chk($sformatf("R12 strobe ends crit%0d", i), {7'd0, nmi_n}, 8'h01);
            repeat (4) cyc();
            chk($sformatf("R12 held no retrigger crit%0d", i), {7'd0, nmi_n}, 8'h01);
            crit_evt = '0;
            cyc(); cyc();
        end

        // R13: second rise during the strobe
        crit_evt = 2'b01;
        cyc();
        chk("R13 first strobe", {7'd0, nmi_n}, 8'h00);
        crit_evt = 2'b11;
        cyc();
        chk("R13 gap cycle", {7'd0, nmi_n}, 8'h01);
        cyc();
        chk("R13 second strobe", {7'd0, nmi_n}, 8'h00);
        cyc();
        chk("R13 back to idle", {7'd0, nmi_n}, 8'h01);
        crit_evt = '0;
        cyc();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule